// File: doc/BRIEF.md
# Edge Mask Video Overlay Mixer

This block prepares the display stream of an edge-detection pipeline. It receives two streams. The first is the raw colour pixel stream, packed as 5/6/5 red/green/blue with its valid flag and three first-pixel tags (line, frame and sequence). The second is the 1-bit edge mask that the filter pipeline produces many cycles later. The colour stream and its tags pass through a fixed alignment delay, so that each original pixel meets the mask bit computed from it. A separate mixer is used for each colour component, and each one builds the displayed value.

A 2-bit runtime mode controls the picture. Bit 0 chooses the background: all-zero (black) when clear, the delayed original pixel when set. Bit 1 enables a white overlay. A mask bit of 1 then forces every bit of every component to one. The mode is taken afresh on every cycle, together with the mask bit, so it may change between any two pixels.

Top module: `edge_overlay_mixer`

## Requirements
- R1: While reset is high, every output is held at zero at the next clock edge, and the alignment pipeline is cleared.
- R2: The colour pixel presented at cycle j is combined with the mask bit and mode presented at cycle j+ALIGN_DELAY (default 13). The result appears at the outputs one cycle later.
- R3: With mode 2'b00, the output pixel is 16'h0000 whatever the mask.
- R4: With mode 2'b01, the output pixel equals the delayed original pixel whatever the mask.
- R5: When mode bit 1 is set and the mask bit is 1, the output is white whatever bit 0 is. White is red[15:11]=5'h1F, green[10:5]=6'h3F and blue[4:0]=5'h1F, which is 16'hFFFF.
- R6: When mode bit 1 is set and the mask bit is 0, the output is the background that bit 0 selects.
- R7: When mode bit 1 is clear, the mask bit has no effect on the output pixel.
- R8: The output line, frame and sequence tags equal the input tags delayed by ALIGN_DELAY+1 cycles.
- R9: The output valid is high exactly when the delayed colour valid and the mask valid are both high, one cycle after they meet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_bit | input | 1 | Edge mask bit from the filter pipeline |
| mask_valid | input | 1 | Mask bit is valid |
| pix_in | input | 16 | Original colour pixel, 5/6/5 red/green/blue |
| pix_valid | input | 1 | Colour pixel is valid |
| line_first_in | input | 1 | First pixel of a line |
| frame_first_in | input | 1 | First pixel of a frame |
| seq_first_in | input | 1 | First pixel of a sequence |
| mode | input | 2 | Bit 0: original background; bit 1: white mask overlay |
| pix_out | output | 16 | Mixed display pixel, 5/6/5 |
| pix_out_valid | output | 1 | Output pixel is valid |
| line_first_out | output | 1 | Delayed line tag |
| frame_first_out | output | 1 | Delayed frame tag |
| seq_first_out | output | 1 | Delayed sequence tag |

## Verification
The hardest case to reach from the ports is a mode change on consecutive pixels while the colour stream and the mask stream sit ALIGN_DELAY cycles apart. Under those conditions an off-by-one in the alignment produces a plausible-looking pixel in the wrong place. The stimulus first holds each mode for a long stretch. It then draws a new mode, mask bit and valid pattern on every cycle, with independent gaps in both valid flags. The expected value for each cycle is built from the pixel the bench itself drove exactly ALIGN_DELAY cycles before the mask bit.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int PIX_W = 16;
    localparam int TAG_W = 3;
    localparam int MODE_W = 2;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb565_t;

    typedef struct packed {
        logic seq;
        logic frame;
        logic line;
    } vtag_t;

    typedef struct packed {
        logic    valid;
        vtag_t   tag;
        rgb565_t pix;
    } vbeat_t;

    localparam int BEAT_W = $bits(vbeat_t);

    typedef enum logic [MODE_W-1:0] {
        MODE_BLACK      = 2'b00,
        MODE_ORIG       = 2'b01,
        MODE_PAINT_DARK = 2'b10,
        MODE_PAINT_ORIG = 2'b11
    } ovl_mode_t;

    function automatic logic keeps_background(input ovl_mode_t m);
        return m[0];
    endfunction

    function automatic logic paints_mask(input ovl_mode_t m);
        return m[1];
    endfunction

    function automatic int chan_lo(input int ch);
        return (ch == 0) ? 0 : (ch == 1) ? 5 : 11;
    endfunction

    function automatic int chan_width(input int ch);
        return (ch == 1) ? 6 : 5;
    endfunction

endpackage

// File: rtl/ovl_align_delay.sv
module ovl_align_delay #(
    parameter int DEPTH = 13,
    parameter int W     = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    generate
        if (DEPTH == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [W-1:0] stage [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                if (i == 0) begin : g_head
                    always_ff @(posedge clk) begin
                        if (rst) stage[0] <= '0;
                        else     stage[0] <= d_in;
                    end
                end else begin : g_body
                    always_ff @(posedge clk) begin
                        if (rst) stage[i] <= '0;
                        else     stage[i] <= stage[i-1];
                    end
                end
            end
            assign d_out = stage[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/ovl_chan_mix.sv
module ovl_chan_mix #(
    parameter int W = 5
) (
    input  logic [W-1:0] bg_val,
    input  logic         keep_bg,
    input  logic         paint,
    input  logic         mask_bit,
    output logic [W-1:0] mix_val
);

    always_comb begin
        if (paint && mask_bit) mix_val = {W{1'b1}};
        else if (keep_bg)      mix_val = bg_val;
        else                   mix_val = '0;
    end

endmodule

// File: rtl/edge_overlay_mixer.sv
module edge_overlay_mixer
    import ovl_pkg::*;
#(
    parameter int ALIGN_DELAY = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mask_bit,
    input  logic        mask_valid,
    input  logic [15:0] pix_in,
    input  logic        pix_valid,
    input  logic        line_first_in,
    input  logic        frame_first_in,
    input  logic        seq_first_in,
    input  logic [1:0]  mode,
    output logic [15:0] pix_out,
    output logic        pix_out_valid,
    output logic        line_first_out,
    output logic        frame_first_out,
    output logic        seq_first_out
);

    localparam int NUM_CH = 3;

    vbeat_t    beat_in;
    vbeat_t    beat_dly;
    ovl_mode_t mode_now;
    logic [PIX_W-1:0] mixed;

    assign mode_now       = ovl_mode_t'(mode);
    assign beat_in.valid  = pix_valid;
    assign beat_in.tag    = '{seq: seq_first_in, frame: frame_first_in, line: line_first_in};
    assign beat_in.pix    = rgb565_t'(pix_in);

    logic [BEAT_W-1:0] beat_dly_bits;

    ovl_align_delay #(
        .DEPTH (ALIGN_DELAY),
        .W     (BEAT_W)
    ) u_align (
        .clk   (clk),
        .rst   (rst),
        .d_in  (beat_in),
        .d_out (beat_dly_bits)
    );

    assign beat_dly = vbeat_t'(beat_dly_bits);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mix
            localparam int LO = chan_lo(ch);
            localparam int CW = chan_width(ch);
            logic [PIX_W-1:0] dly_pix_bits;
            assign dly_pix_bits = beat_dly.pix;
            ovl_chan_mix #(
                .W (CW)
            ) u_mix (
                .bg_val   (dly_pix_bits[LO +: CW]),
                .keep_bg  (keeps_background(mode_now)),
                .paint    (paints_mask(mode_now)),
                .mask_bit (mask_bit),
                .mix_val  (mixed[LO +: CW])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out         <= '0;
            pix_out_valid   <= 1'b0;
            line_first_out  <= 1'b0;
            frame_first_out <= 1'b0;
            seq_first_out   <= 1'b0;
        end else begin
            pix_out         <= mixed;
            pix_out_valid   <= beat_dly.valid & mask_valid;
            line_first_out  <= beat_dly.tag.line;
            frame_first_out <= beat_dly.tag.frame;
            seq_first_out   <= beat_dly.tag.seq;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!pix_out_valid && pix_out == 16'h0000));

    a_r9_valid_needs_mask: assert property (@(posedge clk) disable iff (rst)
        pix_out_valid |-> $past(mask_valid));

    a_r5_white_paint: assert property (@(posedge clk) disable iff (rst)
        ($past(mode[1]) && $past(mask_bit) && !$past(rst)) |-> pix_out == 16'hFFFF);

    a_r3_black_plain: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 2'b00 && !$past(rst)) |-> pix_out == 16'h0000);

endmodule

// File: tb/edge_overlay_mixer_tb.sv
module edge_overlay_mixer_tb;

    localparam int D = 13;
    localparam int N = 800;

    logic        clk = 1'b0;
    logic        rst;
    logic        mask_bit, mask_valid, pix_valid;
    logic [15:0] pix_in;
    logic        line_first_in, frame_first_in, seq_first_in;
    logic [1:0]  mode;
    logic [15:0] pix_out;
    logic        pix_out_valid, line_first_out, frame_first_out, seq_first_out;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic        v;
        logic [15:0] p;
        logic [2:0]  t;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    logic [15:0] h_pix [N];
    logic        h_val [N];
    logic [2:0]  h_tag [N];

    always #2 clk = ~clk;

    edge_overlay_mixer #(.ALIGN_DELAY(D)) u_dut (
        .clk(clk), .rst(rst),
        .mask_bit(mask_bit), .mask_valid(mask_valid),
        .pix_in(pix_in), .pix_valid(pix_valid),
        .line_first_in(line_first_in), .frame_first_in(frame_first_in),
        .seq_first_in(seq_first_in), .mode(mode),
        .pix_out(pix_out), .pix_out_valid(pix_out_valid),
        .line_first_out(line_first_out), .frame_first_out(frame_first_out),
        .seq_first_out(seq_first_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per clock after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " R2 pixel"}, {16'h0, pix_out}, {16'h0, e.p});
                check("R9 valid", {31'h0, pix_out_valid}, {31'h0, e.v});
                check("R8 tags", {29'h0, seq_first_out, frame_first_out, line_first_out},
                      {29'h0, e.t});
            end
        end
    end

    // watchdog
    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        mask_bit = 0; mask_valid = 0; pix_valid = 0; pix_in = '0;
        line_first_in = 0; frame_first_in = 0; seq_first_in = 0; mode = 2'b00;
        repeat (4) @(negedge clk);
        // R1: outputs zero while in reset
        check("R1 pixel", {16'h0, pix_out}, 32'h0);
        check("R1 valid", {31'h0, pix_out_valid}, 32'h0);
        check("R1 tags", {29'h0, seq_first_out, frame_first_out, line_first_out}, 32'h0);
        rst = 1'b0;
        for (int c = 0; c < N; c++) begin
            exp_t e;
            logic [15:0] bg;
            logic        bv;
            logic [2:0]  bt;
            logic [1:0]  m;
            logic        mb;
            // colour stream
            h_pix[c] = 16'($urandom);
            h_val[c] = ($urandom % 5) != 0;
            h_tag[c] = (c % 37 == 0) ? 3'b001 : (c % 111 == 0) ? 3'b011 : 3'b000;
            if (c == 300) h_tag[c] = 3'b111;
            pix_in = h_pix[c];
            pix_valid = h_val[c];
            {seq_first_in, frame_first_in, line_first_in} = h_tag[c];
            // mode schedule: fixed stretches, then per-pixel changes
            if (c < 100)      m = 2'b00;
            else if (c < 200) m = 2'b01;
            else if (c < 300) m = 2'b10;
            else if (c < 400) m = 2'b11;
            else              m = 2'($urandom);
            mb = $urandom % 2;
            mode = m;
            mask_bit = mb;
            mask_valid = ($urandom % 4) != 0;
            // reference: pixel driven D cycles earlier
            if (c >= D) begin
                bg = h_pix[c-D]; bv = h_val[c-D]; bt = h_tag[c-D];
            end else begin
                bg = '0; bv = 1'b0; bt = '0;
            end
            if (m[1] && mb)      begin e.p = 16'hFFFF;  e.req = "R5"; end
            else if (m[0])       begin e.p = bg;        e.req = m[1] ? "R6" : "R4 R7"; end
            else                 begin e.p = 16'h0000;  e.req = m[1] ? "R6" : "R3 R7"; end
            e.v = bv & mask_valid;
            e.t = bt;
            exp_q.push_back(e);
            @(negedge clk);
        end
        mask_valid = 0; pix_valid = 0;
        while (exp_q.size() > 0) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule